// File: doc/BRIEF.md
# Phase Detector with Lock Indicator

This block compares two divided clocks, a reference stream and a feedback stream, and turns their rising-edge timing difference into a drive request for a three-state charge-pump output. When the reference edge comes first, the output is driven to one level for the number of system clocks by which it leads. When the feedback edge comes first, the output is driven to the other level. Once both edges of a comparison have arrived, the output floats. A polarity input swaps the two driven levels, so the block suits loop filters and oscillators of either tuning slope.

Both stream inputs are sampled by the system clock through a synchronizer. A classic two-flag phase-frequency detector then produces an up flag and a down flag. Both flags clear together once both edges have been seen. A lock monitor measures every correction pulse. It raises the lock flag after several consecutive clean comparison periods. A single wide pulse drops the flag. A run input selects normal operation when high. When low, it holds the block in an idle low-power state, with the output floating and the lock flag low. The run input is expected to be low at power-on.

Top module: `phase_detector_lock`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the drive enable, drive level, up, down and lock outputs are all 0.
- R2: When a reference rising edge arrives d system clocks before the feedback rising edge (d >= 1), `up_o` is high for exactly d consecutive cycles, and `down_o` stays low for that comparison.
- R3: When a feedback rising edge arrives d system clocks before the reference rising edge (d >= 1), `down_o` is high for exactly d consecutive cycles, and `up_o` stays low for that comparison.
- R4: When the two edges arrive in the same cycle, neither pulse occurs. `up_o` and `down_o` are never high together. Whenever both are low, `drv_en_o` is 0 (output floating) and `drv_lvl_o` is 0.
- R5: Drive encoding: `drv_en_o` = 1 means the output is driven, and `drv_lvl_o` = 1 means high. With `invert_i` = 0, up drives high and down drives low. With `invert_i` = 1, up drives low and down drives high.
- R6: Two cycles after `run_i` goes low, all outputs are 0 and stay 0 whatever edges arrive. While `run_i` is low, the lock history is discarded.
- R7: A comparison period ends at each reference rising edge. A period is clean when no correction pulse in it reaches LOCK_WIN cycles. `lock_o` rises after LOCK_PERIODS consecutive clean periods (defaults 5 and 4). It stays high while periods remain clean.
- R8: When a correction pulse reaches LOCK_WIN cycles, `lock_o` is low from the next cycle on. The clean-period count restarts from the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Divided reference stream |
| fbk_i | input | 1 | Divided feedback stream |
| invert_i | input | 1 | Polarity select; 1 swaps the driven levels |
| run_i | input | 1 | 1 = normal operation, 0 = low-power idle |
| drv_en_o | output | 1 | Charge-pump drive enable (0 = high impedance) |
| drv_lvl_o | output | 1 | Charge-pump drive level when enabled |
| up_o | output | 1 | Reference-leads correction pulse |
| down_o | output | 1 | Feedback-leads correction pulse |
| lock_o | output | 1 | Lock indicator |

## Verification
The assertions assume that the stream inputs are slow compared with the system clock. Each high and low phase must last several system clocks, and no stream produces a second rising edge before its partner has answered the first. The pulse-width rule also assumes pulses do not overlap a run-input transition. The stimulus drives each comparison period as a fixed 24-cycle frame. The reference rises at cycle 8, and the feedback rises at 8 plus a signed offset of at most 7 cycles. Both fall at cycle 16. The run input changes only at frame boundaries, while both streams are low.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

    // level driven on the pump for a given pulse direction and polarity
    function automatic logic pump_level(input logic up_dir, input logic invert);
        return up_dir ^ invert;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = sig_i;
                st_d.prev  = st_q.chain[0];
            end
        end else begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], sig_i};
                st_d.prev  = st_q.chain[STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ref_rise_i,
    input  logic fbk_rise_i,
    output logic up_o,
    output logic dn_o
);
    pfd_flags_t fl_d, fl_q;

    always_comb begin
        fl_d    = fl_q;
        fl_d.up = fl_q.up | ref_rise_i;
        fl_d.dn = fl_q.dn | fbk_rise_i;
        // both edges seen: common reset of the two flags
        if (fl_d.up && fl_d.dn) begin
            fl_d.up = 1'b0;
            fl_d.dn = 1'b0;
        end
        if (!active_i) begin
            fl_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign up_o = fl_q.up;
    assign dn_o = fl_q.dn;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
    parameter int LOCK_WIN     = 5,
    parameter int LOCK_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ref_rise_i,
    input  logic up_i,
    input  logic dn_i,
    output logic lock_o
);
    localparam int WW = $clog2(LOCK_WIN + 1);
    localparam int GW = $clog2(LOCK_PERIODS + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(LOCK_WIN - 1);
    localparam logic [WW-1:0] WIN_MAX  = WW'(LOCK_WIN);
    localparam logic [GW-1:0] GOOD_MAX = GW'(LOCK_PERIODS);

    typedef struct packed {
        logic [WW-1:0] width;
        logic [GW-1:0] good;
        logic          wide_seen;
        logic          lock;
    } lock_state_t;

    lock_state_t st_d, st_q;
    logic        pulse_on;
    logic        too_wide;

    always_comb begin
        st_d     = st_q;
        pulse_on = up_i | dn_i;
        too_wide = pulse_on && (st_q.width >= WIN_LAST);

        if (pulse_on) begin
            if (st_q.width != WIN_MAX) st_d.width = st_q.width + 1'b1;
        end else begin
            st_d.width = '0;
        end

        if (too_wide) begin
            st_d.lock      = 1'b0;
            st_d.good      = '0;
            st_d.wide_seen = 1'b1;
        end

        if (ref_rise_i) begin
            st_d.wide_seen = 1'b0;
            if (too_wide || st_q.wide_seen) begin
                st_d.good = '0;
            end else if (st_q.good != GOOD_MAX) begin
                st_d.good = st_q.good + 1'b1;
            end
            st_d.lock = (st_d.good == GOOD_MAX);
        end

        if (!active_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock;
endmodule

// File: rtl/phase_detector_lock.sv
module phase_detector_lock
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int LOCK_WIN     = 5,
    parameter int LOCK_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic fbk_i,
    input  logic invert_i,
    input  logic run_i,
    output logic drv_en_o,
    output logic drv_lvl_o,
    output logic up_o,
    output logic down_o,
    output logic lock_o
);
    typedef struct packed {
        logic run;
    } top_state_t;

    top_state_t st_d, st_q;
    logic ref_rise, fbk_rise;
    logic up_w, dn_w;

    always_comb begin
        st_d     = st_q;
        st_d.run = run_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .sig_i(ref_i), .rise_o(ref_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fbk_sync (
        .clk(clk), .rst_n(rst_n), .sig_i(fbk_i), .rise_o(fbk_rise)
    );

    pfd_core u_core (
        .clk(clk), .rst_n(rst_n), .active_i(st_q.run),
        .ref_rise_i(ref_rise), .fbk_rise_i(fbk_rise),
        .up_o(up_w), .dn_o(dn_w)
    );

    pfd_lock_mon #(.LOCK_WIN(LOCK_WIN), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
        .clk(clk), .rst_n(rst_n), .active_i(st_q.run),
        .ref_rise_i(ref_rise), .up_i(up_w), .dn_i(dn_w),
        .lock_o(lock_o)
    );

    always_comb begin
        drv_en_o  = up_w | dn_w;
        drv_lvl_o = 1'b0;
        if (up_w)      drv_lvl_o = pump_level(1'b1, invert_i);
        else if (dn_w) drv_lvl_o = pump_level(1'b0, invert_i);
    end

    assign up_o   = up_w;
    assign down_o = dn_w;
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int LOCK_WIN = 5
) (
    input logic clk,
    input logic rst_n,
    input logic run_i,
    input logic invert_i,
    input logic drv_en_o,
    input logic drv_lvl_o,
    input logic up_o,
    input logic down_o,
    input logic lock_o
);
    localparam int CW = $clog2(LOCK_WIN + 1);
    logic [CW-1:0] run_len_q;

    // consecutive cycles a correction pulse has been present
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          run_len_q <= '0;
        else if (!(up_o || down_o))          run_len_q <= '0;
        else if (run_len_q != CW'(LOCK_WIN)) run_len_q <= run_len_q + 1'b1;
    end

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_o, down_o}));

    p_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_o && !down_o) |-> (!drv_en_o && !drv_lvl_o));

    p_up_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        up_o |-> (drv_en_o && (drv_lvl_o == !invert_i)));

    p_dn_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        down_o |-> (drv_en_o && (drv_lvl_o == invert_i)));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_i) && !$past(run_i, 2)) |-> (!drv_en_o && !up_o && !down_o && !lock_o));

    p_wide_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_o || down_o) && (run_len_q >= CW'(LOCK_WIN - 1))) |=> !lock_o);
endmodule

bind phase_detector_lock pfd_checker #(.LOCK_WIN(LOCK_WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .invert_i(invert_i),
    .drv_en_o(drv_en_o), .drv_lvl_o(drv_lvl_o), .up_o(up_o),
    .down_o(down_o), .lock_o(lock_o)
);

// File: tb/tb_phase_detector_lock.sv
module tb_phase_detector_lock;
    localparam int WIN   = 5;
    localparam int NPER  = 4;
    localparam int FRAME = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_i = 1'b0, fbk_i = 1'b0, invert_i = 1'b0, run_i = 1'b0;
    logic drv_en_o, drv_lvl_o, up_o, down_o, lock_o;

    int tests = 0;
    int fails = 0;
    int good_m = 0;
    bit wide_pend = 1'b0;

    always #10 clk = ~clk;

    phase_detector_lock #(.SYNC_STAGES(2), .LOCK_WIN(WIN), .LOCK_PERIODS(NPER)) dut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fbk_i(fbk_i),
        .invert_i(invert_i), .run_i(run_i), .drv_en_o(drv_en_o),
        .drv_lvl_o(drv_lvl_o), .up_o(up_o), .down_o(down_o), .lock_o(lock_o)
    );

    function automatic int exp_up(input int d);
        return (d > 0) ? d : 0;
    endfunction

    function automatic int exp_dn(input int d);
        return (d < 0) ? -d : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // one comparison frame: reference rises at 8, feedback at 8+d, both fall at 16
    task automatic frame(input int d, input logic inv, input logic run);
        int ups = 0;
        int dns = 0;
        bit bad_edge;
        bit exp_lock;
        for (int c = 0; c < FRAME; c++) begin
            @(negedge clk);
            if (up_o) ups++;
            if (down_o) dns++;
            if (up_o || down_o) begin
                check("R5 driven level", {31'b0, drv_en_o} * 2 + drv_lvl_o,
                      2 + (up_o ? !invert_i : invert_i));
                check("R4 exclusive", up_o & down_o, 0);
            end else if (c % 4 == 0) begin
                check("R4 float", {drv_en_o, drv_lvl_o}, 0);
            end
            if (!run && c >= 3)
                check("R6 idle", {drv_en_o, up_o, down_o, lock_o}, 0);
            if (c == 0) begin
                invert_i = inv;
                run_i    = run;
            end
            ref_i = (c >= 8 && c < 16);
            fbk_i = (c >= 8 + d && c < 16);
        end
        // pulses of this frame were all counted inside it
        if (run) begin
            check(d >= 0 ? "R2 up width" : "R3 up absent", ups, exp_up(d));
            check(d <= 0 ? "R3 down width" : "R2 down absent", dns, exp_dn(d));
        end
        // lock model: a period ends at a reference edge
        if (!run) begin
            good_m = 0;
            wide_pend = 1'b0;
            exp_lock = 1'b0;
        end else begin
            bad_edge = wide_pend || (d <= -WIN);
            if (bad_edge) good_m = 0;
            else if (good_m < NPER) good_m++;
            wide_pend = (d >= WIN);
            exp_lock = (good_m >= NPER) && !wide_pend;
        end
        check((d >= WIN || d <= -WIN) ? "R8 lock loss" : "R7 lock state", lock_o, exp_lock);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {drv_en_o, drv_lvl_o, up_o, down_o, lock_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {drv_en_o, drv_lvl_o, up_o, down_o, lock_o}, 0);
        frame(0, 1'b0, 1'b0);

        // R7: aligned edges acquire lock after four clean periods
        for (int i = 0; i < 6; i++) frame(0, 1'b0, 1'b1);
        // R2 / R3 boundary just below the window keeps lock
        frame(WIN - 1, 1'b0, 1'b1);
        frame(-(WIN - 1), 1'b1, 1'b1);
        frame(1, 1'b1, 1'b1);
        frame(-1, 1'b0, 1'b1);
        // R8: lagging wide pulse drops lock at once
        frame(WIN, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) frame(2, 1'b1, 1'b1);
        // R8: leading wide pulse
        frame(-7, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) frame(-2, 1'b0, 1'b1);
        // R6: power save ignores edges and clears lock history
        frame(3, 1'b0, 1'b0);
        frame(-3, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) frame(0, 1'b0, 1'b1);

        // random mix, biased towards small offsets
        for (int i = 0; i < 60; i++) begin
            int d;
            int sel;
            sel = $urandom_range(0, 9);
            d = (sel < 7) ? $urandom_range(0, 8) - 4 : $urandom_range(0, 14) - 7;
            frame(d, 1'($urandom_range(0, 1)), (sel == 9) ? 1'b0 : 1'b1);
        end
        summary();
    end
endmodule